// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to `NUM_SRC` interrupt requests, keeps each one in a sticky pending bit and lets an enable mask decide which pending sources may reach the processor. It raises one interrupt line and presents a vector address with it. A source is in one of two modes. In normal mode the vector is a shared default, derived from a configured base. In fast mode the vector is a per-source address that software has programmed.

Software uses a small word-addressed register bus. Through it, software sets the enable and mode masks and programs the per-source vectors. It clears pending bits through a write-one-to-clear acknowledge register, and reads back the pending, enable and mode state. The processor answers with a one-cycle acknowledge pulse. The winning source and its vector are registered when the grant is made. They stay fixed until that pulse arrives, or until the granted source stops being pending and enabled.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A request input that is high at a clock edge sets its pending bit, and the bit stays set after the request drops. Pending is read at byte address 0x00, with bit k for source k.
- R2: If a source's enable bit is clear, its pending bit stays latched, but that source never raises `irq_o`. The enable register is read and written at 0x04, with bit k for source k.
- R3: A write to the acknowledge register at 0x08 clears exactly the pending bits written as 1. Bits written as 0 keep their state. Writing all ones clears every pending bit. Reads of 0x08 return 0.
- R4: If a request is high in the same cycle that an acknowledge write clears its bit, the request wins and the bit stays pending.
- R5: Among sources that are pending and enabled, the one with the lowest index is granted. Source 0 has the highest priority.
- R6: The mode register at 0x0C holds one bit per source. A granted source with its mode bit clear gets the vector (BASE_VECTOR & ~0x7F) | 0x10. With its mode bit set, it gets its own vector register, written at byte address VEC_BASE + 4*k (0x80 + 4*k by default).
- R7: A grant takes effect one cycle after its source becomes pending and enabled. While the granted source stays pending and enabled and no processor acknowledge arrives, `irq_vec_o` holds its value, even if a higher-priority source becomes active.
- R8: A processor acknowledge pulse releases the grant, so `irq_o` is low in the following cycle. If the granted source was in fast mode, the same pulse also clears its pending bit. In normal mode the pending bit stays set until software acknowledges it.
- R9: After reset, the pending, enable and mode registers are all zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt request inputs, level or pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write byte address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read byte address |
| rd_data_o | output | DATA_W | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_vec_o | output | DATA_W | Vector address of the granted source |
| proc_ack_i | input | 1 | One-cycle processor acknowledge |

## Verification
The assertions assume two things about the processor. First, it pulses `proc_ack_i` only while `irq_o` is high. Second, it writes only word-aligned addresses. The stimulus meets both. Every acknowledge pulse is issued after the bench has seen `irq_o` high, and every address comes from the fixed offsets or from VEC_BASE + 4*k. Requests are driven one cycle at a time, away from the clock edge, so each pending bit is set at a known edge. This holds even in the cycles that test collisions with the acknowledge register.

// File: rtl/vic_pkg.sv
package vic_pkg;
   // byte offsets of the control registers; vectors live at VEC_BASE parameter
   localparam int unsigned OFS_PEND = 32'h00;
   localparam int unsigned OFS_ENA  = 32'h04;
   localparam int unsigned OFS_ACK  = 32'h08;
   localparam int unsigned OFS_MODE = 32'h0C;

   function automatic logic [31:0] vic_default_vec(input logic [31:0] base);
      return (base & ~32'h0000_007F) | 32'h0000_0010;
   endfunction
endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank #(
   parameter int NUM_SRC     = 32,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] pend_o
);
   logic [NUM_SRC-1:0] src_s;
   logic [NUM_SRC-1:0] pend_q;

   generate
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must be non-negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign src_s = src_i;
      end else begin : g_sync
         logic [NUM_SRC-1:0] stage_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
            end else begin
               stage_q[0] <= src_i;
               for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
            end
         end
         assign src_s = stage_q[SYNC_STAGES-1];
      end
   endgenerate

   // a set request overrides a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_i) | src_s;
   end

   assign pend_o = pend_q;

   assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(src_s)) == $past(src_s)));

   assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(clr_i & ~src_s)) == '0));

   assert_pending_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
   parameter int NUM_SRC = 32,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] req_i,
   output logic               any_o,
   output logic [IDX_W-1:0]   idx_o
);
   // lowest index wins: scan downwards so the last hit is the smallest
   always_comb begin
      any_o = |req_i;
      idx_o = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
   parameter int          NUM_SRC     = 32,
   parameter int          ADDR_W      = 8,
   parameter int          DATA_W      = 32,
   parameter logic [31:0] BASE_VECTOR = 32'h0000_2345,
   parameter int          VEC_BASE    = 128,
   parameter int          SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               wr_en_i,
   input  logic [ADDR_W-1:0]  wr_addr_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   input  logic [ADDR_W-1:0]  rd_addr_i,
   output logic [DATA_W-1:0]  rd_data_o,
   output logic               irq_o,
   output logic [DATA_W-1:0]  irq_vec_o,
   input  logic               proc_ack_i
);
   import vic_pkg::*;

   localparam int          IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam logic [31:0] DEF_VEC = vic_default_vec(BASE_VECTOR);

   generate
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_count
         $error("NUM_SRC must lie in 1..DATA_W");
      end
      if (DATA_W < 32) begin : g_bad_width
         $error("DATA_W must be at least 32");
      end
      if ((VEC_BASE % 4) != 0 || VEC_BASE < 16) begin : g_bad_base
         $error("VEC_BASE must be word aligned and above the control registers");
      end
      if (VEC_BASE + 4 * NUM_SRC > (1 << ADDR_W)) begin : g_bad_span
         $error("vector registers do not fit the address space");
      end
   endgenerate

   logic [NUM_SRC-1:0] en_q, mode_q, pend, active;
   logic [DATA_W-1:0]  vec_q [NUM_SRC];
   logic [NUM_SRC-1:0] sw_clr, hw_clr;
   logic               pick_any;
   logic [IDX_W-1:0]   pick_idx;
   logic               gnt_vld_q, gnt_fast_q;
   logic [IDX_W-1:0]   gnt_id_q;
   logic [DATA_W-1:0]  gnt_vec_q;
   logic               gnt_live;

   // ---------------- register writes ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         mode_q <= '0;
      end else if (wr_en_i) begin
         if (wr_addr_i == ADDR_W'(OFS_ENA))  en_q   <= wr_data_i[NUM_SRC-1:0];
         if (wr_addr_i == ADDR_W'(OFS_MODE)) mode_q <= wr_data_i[NUM_SRC-1:0];
      end
   end

   generate
      for (genvar k = 0; k < NUM_SRC; k++) begin : g_vec
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               vec_q[k] <= DATA_W'(DEF_VEC);
            else if (wr_en_i && wr_addr_i == ADDR_W'(VEC_BASE + 4 * k))
               vec_q[k] <= wr_data_i;
         end
      end
   endgenerate

   assign sw_clr = (wr_en_i && wr_addr_i == ADDR_W'(OFS_ACK)) ? wr_data_i[NUM_SRC-1:0] : '0;
   assign hw_clr = (gnt_vld_q && proc_ack_i && gnt_fast_q) ? (NUM_SRC'(1) << gnt_id_q) : '0;

   // ---------------- pending and priority ----------------
   vic_src_bank #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i),
      .clr_i  (sw_clr | hw_clr),
      .pend_o (pend)
   );

   assign active = pend & en_q;

   vic_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .req_i (active),
      .any_o (pick_any),
      .idx_o (pick_idx)
   );

   // ---------------- registered grant ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_vld_q  <= 1'b0;
         gnt_fast_q <= 1'b0;
         gnt_id_q   <= '0;
         gnt_vec_q  <= DATA_W'(DEF_VEC);
      end else if (gnt_vld_q) begin
         if (proc_ack_i || !active[gnt_id_q]) gnt_vld_q <= 1'b0;
      end else if (pick_any) begin
         gnt_vld_q  <= 1'b1;
         gnt_id_q   <= pick_idx;
         gnt_fast_q <= mode_q[pick_idx];
         gnt_vec_q  <= mode_q[pick_idx] ? vec_q[pick_idx] : DATA_W'(DEF_VEC);
      end
   end

   assign gnt_live  = gnt_vld_q && active[gnt_id_q];
   assign irq_o     = gnt_live;
   assign irq_vec_o = gnt_vec_q;

   // ---------------- register reads ----------------
   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == ADDR_W'(OFS_PEND))      rd_data_o[NUM_SRC-1:0] = pend;
      else if (rd_addr_i == ADDR_W'(OFS_ENA))  rd_data_o[NUM_SRC-1:0] = en_q;
      else if (rd_addr_i == ADDR_W'(OFS_MODE)) rd_data_o[NUM_SRC-1:0] = mode_q;
   end

   // ---------------- assertions ----------------
   assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & en_q) == '0) |-> !irq_o);

   assert_vector_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !proc_ack_i) |=> $stable(irq_vec_o));

   assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && proc_ack_i) |=> !irq_o);

   assert_reset_quiet_R9: assert property (@(posedge clk)
      !rst_n |-> !irq_o);
endmodule

// File: tb/sim_vec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vec_irq_ctrl;
   localparam int          N    = 32;
   localparam int          AW   = 8;
   localparam int          DW   = 32;
   localparam logic [31:0] BASE = 32'h0000_2345;
   localparam logic [31:0] DEFV = 32'h0000_2310;   // (BASE & ~0x7F) | 0x10
   localparam int          VB   = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          irq;
   logic [DW-1:0] irq_vec;
   logic          pack = 1'b0;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;

   always #2.5 clk = ~clk;

   vec_irq_ctrl #(.NUM_SRC(N), .ADDR_W(AW), .DATA_W(DW), .BASE_VECTOR(BASE),
                  .VEC_BASE(VB), .SYNC_STAGES(0)) u0 (
      .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .irq_o(irq), .irq_vec_o(irq_vec), .proc_ack_i(pack));

   // rows: {source pulse, enable mask, mode mask}
   localparam logic [95:0] TBL [6] = '{
      {32'h0000_0011, 32'hFFFF_FFFF, 32'h0000_0000},
      {32'h0000_0011, 32'hFFFF_FFFE, 32'h0000_0010},
      {32'h8000_0000, 32'h8000_0000, 32'h8000_0000},
      {32'h0000_0F00, 32'h0000_0C00, 32'h0000_0400},
      {32'h0000_00F0, 32'h0000_0000, 32'h0000_00FF},
      {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0001}
   };

   function automatic logic [31:0] own_vec(input int k);
      return 32'hA000_0000 + 32'(k) * 32'h10;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [31:0] s);
      @(negedge clk);
      src = s;
      @(negedge clk);
      src = '0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      rd_addr = AW'(a);
      #0.5;
      d = rd_data;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic clean();
      wr(32'h04, 32'h0);
      wr(32'h08, 32'hFFFF_FFFF);
      idle(2);
   endtask

   initial begin
      logic [31:0] d;
      logic [31:0] s, e, m, act, ev;
      int          win;

      idle(3);
      // R9: reset state
      chk("R9 irq after reset", 32'(irq), 32'h0);
      rd(32'h00, d); chk("R9 pending after reset", d, 32'h0);
      rd(32'h04, d); chk("R9 enable after reset", d, 32'h0);
      rd(32'h0C, d); chk("R9 mode after reset", d, 32'h0);
      @(negedge clk) rst_n = 1'b1;
      idle(2);

      for (int k = 0; k < N; k++) wr(VB + 4 * k, own_vec(k));

      // table walk: R1, R5, R6
      for (int r = 0; r < 6; r++) begin
         s = TBL[r][95:64]; e = TBL[r][63:32]; m = TBL[r][31:0];
         clean();
         wr(32'h0C, m);
         wr(32'h04, e);
         pulse(s);
         idle(2);
         rd(32'h00, d); chk("R1 pending latched", d, s);
         act = s & e;
         win = -1;
         for (int k = N - 1; k >= 0; k--) if (act[k]) win = k;
         chk("R5 irq raised", 32'(irq), (win >= 0) ? 32'h1 : 32'h0);
         if (win >= 0) begin
            ev = m[win] ? own_vec(win) : DEFV;
            chk("R6 vector of winner", irq_vec, ev);
         end
      end

      // R2: disabled source stays pending, no interrupt
      clean();
      wr(32'h0C, 32'h0);
      pulse(32'h0000_0020);
      idle(2);
      chk("R2 masked irq low", 32'(irq), 32'h0);
      rd(32'h00, d); chk("R2 masked still pending", d, 32'h0000_0020);
      wr(32'h04, 32'h0000_0020);
      idle(2);
      chk("R2 irq after enable", 32'(irq), 32'h1);

      // R3: partial acknowledge
      clean();
      pulse(32'h0000_0028);
      wr(32'h08, 32'h0000_0008);
      rd(32'h00, d); chk("R3 partial ack", d, 32'h0000_0020);
      rd(32'h08, d); chk("R3 ack reads zero", d, 32'h0);
      wr(32'h08, 32'hFFFF_FFFF);
      rd(32'h00, d); chk("R3 all-ones ack", d, 32'h0);

      // R4: request and acknowledge in the same cycle
      clean();
      pulse(32'h0000_000C);
      @(negedge clk);
      src = 32'h0000_0004; wr_en = 1'b1; wr_addr = AW'(32'h08); wr_data = 32'h0000_000C;
      @(negedge clk);
      src = '0; wr_en = 1'b0;
      rd(32'h00, d); chk("R4 set beats clear", d, 32'h0000_0004);

      // R7 and R8: grant hold, fast acknowledge, then normal acknowledge
      clean();
      wr(32'h0C, 32'h0000_0040);
      wr(32'h04, 32'hFFFF_FFFF);
      pulse(32'h0000_0040);
      idle(1);
      chk("R7 fast grant", irq_vec, own_vec(6));
      pulse(32'h0000_0002);
      idle(2);
      chk("R7 vector held", irq_vec, own_vec(6));
      chk("R7 irq held", 32'(irq), 32'h1);
      @(negedge clk) pack = 1'b1;
      @(negedge clk) pack = 1'b0;
      chk("R8 irq drops after ack", 32'(irq), 32'h0);
      rd(32'h00, d); chk("R8 fast ack clears pending", d, 32'h0000_0002);
      @(negedge clk);
      chk("R8 next source granted", 32'(irq), 32'h1);
      chk("R6 normal default vector", irq_vec, DEFV);
      @(negedge clk) pack = 1'b1;
      @(negedge clk) pack = 1'b0;
      chk("R8 normal ack drops irq", 32'(irq), 32'h0);
      rd(32'h00, d); chk("R8 normal ack keeps pending", d, 32'h0000_0002);
      @(negedge clk);
      chk("R8 normal source regranted", 32'(irq), 32'h1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 20000; i++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule